// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of the kind found three at a time in a classic interval timer. A count-enable pulse (`tick`) advances it. A load strobe installs a new count together with an operating mode, and a gate input controls it. A bus interface outside this block reads the live count and the OUT level. Six operating modes shape OUT and set what the gate does:

- Mode 0: event flag.
- Mode 1: retriggerable one-shot.
- Mode 2: rate pulse.
- Mode 3: square wave.
- Mode 4: software strobe.
- Mode 5: gate-triggered strobe.

A load takes effect on the first enabled tick after it. That tick transfers the count and does not decrement it. The count loaded in that tick is the loaded value, except in mode 3, where it is the first half-period value. In modes 1 and 5, and after any retrigger, that transfer tick is the first tick after the gate edge has been registered.

No data stream passes through the channel. `load` is a plain strobe that is accepted in every cycle, so there is no back-pressure. A load in the same cycle as a tick wins, and that tick is ignored. Only binary counting is provided.

Top module: `interval_channel`

## Requirements
- R1: After reset the channel is idle: `out_level` is 0 and `count_val` is 0, and ticks change neither until the first load.
- R2: A loaded count of 0 is treated as 65536. In mode 2 it runs 0 → 0xFFFF without a reload. In mode 3 its first half-count is 0, followed by 0xFFFE.
- R3: `mode_sel` 6 acts as mode 2 and 7 acts as mode 3.
- R4: Mode 0: OUT goes low at the load. It rises on the tick that brings the count to 0 and stays high. While `gate` is low, ticks do not decrement.
- R5: Mode 1: after a load, OUT is high and the count waits. A registered gate rising edge makes the next tick load the count and drive OUT low. OUT goes high when the count reaches 0. A later rising edge restarts the count. The gate level does not pause counting.
- R6: Mode 2: OUT is low during counting. On the tick where the count is 1, the count reloads and OUT is high until the next tick. Gate low holds the count. A gate rising edge restarts the count.
- R7: Mode 3: the count steps down by 2 per tick, starting from N rounded up to even. The high phase lasts (N+1)/2 ticks (integer division), then the count restarts from N rounded down to even and the low phase lasts N/2 ticks, then the cycle repeats.
- R8: Modes 4 and 5: OUT is low, except for one tick after the tick that brings the count to 0, and the channel does not reload. In mode 5 counting waits for a gate rising edge, and each later edge re-arms the channel.
- R9: In modes 0, 1, 4 and 5 the count keeps decrementing past 0 and wraps to 0xFFFF.
- R10: The count changes only on a tick. A load leaves the count untouched until the next enabled tick, which installs the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse, one clock wide |
| load | input | 1 | Load strobe for count and mode |
| load_value | input | 16 | Initial count; 0 means 65536 |
| mode_sel | input | 3 | Operating mode, 0 to 7 |
| gate | input | 1 | Gate level |
| count_val | output | 16 | Live count |
| out_level | output | 1 | OUT pin level |

## Verification
Each mode is driven with a small count and then stepped tick by tick. This places every OUT transition on an exact tick and separates modes that share a reload rule but shape OUT differently (mode 2 against mode 3, mode 4 against mode 5).

Gate patterns test three distinct gate roles:
- A low gate with ticks running tells hold-type modes from trigger-type modes.
- A low-then-high gate tells retriggering from plain resumption.
- A low gate right after a load shows that modes 1 and 5 wait for a trigger.

Counts of 0 and odd counts in mode 3 exercise the 65536 rule and the uneven half-periods. Runs past terminal count show wrap in the one-shot modes and reload in the periodic ones.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef enum logic [2:0] {
    M_EVT    = 3'd0,
    M_ONESHOT= 3'd1,
    M_RATE   = 3'd2,
    M_SQW    = 3'd3,
    M_SWSTB  = 3'd4,
    M_HWSTB  = 3'd5
  } tmode_e;

  function automatic logic waits_trig(tmode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  function automatic logic can_retrig(tmode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQW) || (m == M_HWSTB);
  endfunction

  function automatic logic gate_holds(tmode_e m);
    return (m == M_EVT) || (m == M_RATE) || (m == M_SQW) || (m == M_SWSTB);
  endfunction

  function automatic logic level_at_load(tmode_e m);
    return (m == M_ONESHOT) || (m == M_SQW);
  endfunction
endpackage

// File: rtl/chan_mode_decode.sv
module chan_mode_decode
  import chan_pkg::*;
(
  input  logic [2:0] raw_i,
  output tmode_e     mode_o
);
  always_comb begin
    if (raw_i[2] && raw_i[1]) mode_o = tmode_e'({1'b0, raw_i[1:0]});
    else                      mode_o = tmode_e'(raw_i);
  end

  always_comb begin
    assert_alias_R3: assert (!(raw_i[2] && raw_i[1]) || (3'(mode_o) == raw_i - 3'd4));
  end
endmodule

// File: rtl/chan_gate_sense.sv
module chan_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_d;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_d <= 1'b0;
    else        gate_d <= gate_i;
  end

  assign rise_o = gate_i & ~gate_d;
endmodule

// File: rtl/chan_count_core.sv
module chan_count_core
  import chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  tmode_e        load_mode,
  input  logic          gate,
  input  logic          gate_rise,
  output logic [CW-1:0] cnt_o,
  output logic          out_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  tmode_e        mode_q;
  logic          idle_q, pend_q, trig_q, armed_q, out_q;
  logic [CW-1:0] cnt_q, reload_q;

  logic [CW-1:0] hi_val, lo_val, first_val;
  logic          start_now, retrig_now, step_ok, edge_ok;

  assign hi_val     = (reload_q + ONE) & ~ONE;
  assign lo_val     = reload_q & ~ONE;
  assign first_val  = (mode_q == M_SQW) ? hi_val : reload_q;
  assign start_now  = pend_q && (!waits_trig(mode_q) || trig_q);
  assign retrig_now = !pend_q && trig_q && can_retrig(mode_q);
  assign step_ok    = !pend_q && (gate || !gate_holds(mode_q));
  assign edge_ok    = gate_rise && can_retrig(mode_q) && !idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_EVT;
      idle_q   <= 1'b1;
      pend_q   <= 1'b0;
      trig_q   <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= 1'b0;
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      mode_q   <= load_mode;
      idle_q   <= 1'b0;
      pend_q   <= 1'b1;
      trig_q   <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= level_at_load(load_mode);
      reload_q <= load_val;
    end else begin
      if (tick)         trig_q <= edge_ok;
      else if (edge_ok) trig_q <= 1'b1;

      if (tick && !idle_q) begin
        if (start_now || retrig_now) begin
          cnt_q   <= first_val;
          out_q   <= (mode_q == M_SQW);
          armed_q <= 1'b1;
          pend_q  <= 1'b0;
        end else if (step_ok) begin
          unique case (mode_q)
            M_EVT, M_ONESHOT: begin
              cnt_q <= cnt_q - ONE;
              if (cnt_q == ONE && armed_q) begin
                out_q   <= 1'b1;
                armed_q <= 1'b0;
              end
            end
            M_RATE: begin
              if (cnt_q == ONE) begin
                cnt_q <= reload_q;
                out_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q - ONE;
                out_q <= 1'b0;
              end
            end
            M_SQW: begin
              if (cnt_q == TWO) begin
                cnt_q <= out_q ? lo_val : hi_val;
                out_q <= ~out_q;
              end else begin
                cnt_q <= cnt_q - TWO;
              end
            end
            default: begin
              cnt_q <= cnt_q - ONE;
              out_q <= (cnt_q == ONE) && armed_q;
              if (cnt_q == ONE) armed_q <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> (!out_q && cnt_q == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

  assert_sqw_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQW && !idle_q && !pend_q) |-> (cnt_q[0] == 1'b0));

  assert_wait_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && waits_trig(mode_q) && !trig_q && !load) |=> $stable(cnt_q));

  assert_strobe_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTB || mode_q == M_HWSTB) && out_q && tick && !load && !trig_q
     && (gate || mode_q == M_HWSTB)) |=> !out_q);
endmodule

// File: rtl/interval_channel.sv
module interval_channel
  import chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_value,
  input  logic [2:0]    mode_sel,
  input  logic          gate,
  output logic [CW-1:0] count_val,
  output logic          out_level
);
  tmode_e dec_mode;
  logic   gate_rise;

  chan_mode_decode u_dec (
    .raw_i  (mode_sel),
    .mode_o (dec_mode)
  );

  chan_gate_sense u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  chan_count_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .load_val  (load_value),
    .load_mode (dec_mode),
    .gate      (gate),
    .gate_rise (gate_rise),
    .cnt_o     (count_val),
    .out_o     (out_level)
  );
endmodule

// File: tb/tb_interval_channel.sv
`timescale 1ns/1ps
module tb_interval_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_value = '0;
  logic [2:0]  mode_sel = '0;
  logic        gate = 1'b0;
  logic [15:0] count_val;
  logic        out_level;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  interval_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_value(load_value), .mode_sel(mode_sel), .gate(gate),
    .count_val(count_val), .out_level(out_level)
  );

  task automatic chk(string req, logic [15:0] ec, logic eo);
    total++;
    if (count_val !== ec || out_level !== eo) begin
      bad++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b", req, count_val, out_level, ec, eo);
    end
  endtask

  task automatic chk_out(string req, logic eo);
    total++;
    if (out_level !== eo) begin
      bad++;
      $display("FAIL %s: out=%b expected out=%b", req, out_level, eo);
    end
  endtask

  task automatic do_load(logic [2:0] m, logic [15:0] v);
    load = 1'b1; mode_sel = m; load_value = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set_gate(logic v);
    gate = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset", 16'h0000, 1'b0);
    do_tick(3);
    chk("R1 idle ticks", 16'h0000, 1'b0);
  endtask

  task automatic t_mode0;
    set_gate(1'b1);
    do_load(3'd0, 16'd5);
    chk_out("R4 low at load", 1'b0);
    do_tick(1); chk("R10 load on tick", 16'd5, 1'b0);
    do_tick(4); chk("R4 counting", 16'd1, 1'b0);
    do_tick(1); chk("R4 terminal", 16'd0, 1'b1);
    do_tick(1); chk("R9 wrap mode0", 16'hFFFF, 1'b1);
    do_load(3'd0, 16'd3);
    do_tick(1); chk("R4 reload", 16'd3, 1'b0);
    set_gate(1'b0);
    do_tick(3); chk("R4 gate hold", 16'd3, 1'b0);
    set_gate(1'b1);
    do_tick(1); chk("R4 resume", 16'd2, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 no tick no change", 16'd2, 1'b0);
  endtask

  task automatic t_mode1;
    logic [15:0] c0;
    set_gate(1'b0);
    do_load(3'd1, 16'd3);
    chk_out("R5 high at load", 1'b1);
    c0 = count_val;
    do_tick(2); chk("R5 waits for trigger", c0, 1'b1);
    set_gate(1'b1);
    do_tick(1); chk("R5 triggered", 16'd3, 1'b0);
    do_tick(2); chk("R5 counting", 16'd1, 1'b0);
    do_tick(1); chk("R5 terminal", 16'd0, 1'b1);
    do_tick(1); chk("R9 wrap mode1", 16'hFFFF, 1'b1);
    set_gate(1'b0);
    set_gate(1'b1);
    do_tick(1); chk("R5 retrigger", 16'd3, 1'b0);
  endtask

  task automatic t_mode2;
    do_load(3'd2, 16'd3);
    do_tick(1); chk("R6 start", 16'd3, 1'b0);
    do_tick(2); chk("R6 count", 16'd1, 1'b0);
    do_tick(1); chk("R6 pulse reload", 16'd3, 1'b1);
    do_tick(1); chk("R6 pulse ends", 16'd2, 1'b0);
    set_gate(1'b0);
    do_tick(1); chk("R6 gate hold", 16'd2, 1'b0);
    set_gate(1'b1);
    do_tick(1); chk("R6 retrigger", 16'd3, 1'b0);
    do_load(3'd6, 16'd2);
    do_tick(2); chk("R3 mode6 count", 16'd1, 1'b0);
    do_tick(1); chk("R3 mode6 as rate", 16'd2, 1'b1);
  endtask

  task automatic t_mode3;
    do_load(3'd3, 16'd5);
    chk_out("R7 high at load", 1'b1);
    do_tick(1); chk("R7 hi start", 16'd6, 1'b1);
    do_tick(2); chk("R7 step two", 16'd2, 1'b1);
    do_tick(1); chk("R7 low phase", 16'd4, 1'b0);
    do_tick(1); chk("R7 low step", 16'd2, 1'b0);
    do_tick(1); chk("R7 back high", 16'd6, 1'b1);
    do_load(3'd7, 16'd4);
    do_tick(2); chk("R3 mode7 step", 16'd2, 1'b1);
    do_tick(1); chk("R3 mode7 as square", 16'd4, 1'b0);
  endtask

  task automatic t_mode45;
    logic [15:0] c0;
    do_load(3'd4, 16'd2);
    chk_out("R8 low at load", 1'b0);
    do_tick(2); chk("R8 count", 16'd1, 1'b0);
    do_tick(1); chk("R8 strobe", 16'd0, 1'b1);
    do_tick(1); chk("R8 strobe one tick", 16'hFFFF, 1'b0);
    set_gate(1'b0);
    do_load(3'd5, 16'd2);
    c0 = count_val;
    do_tick(2); chk("R8 mode5 waits", c0, 1'b0);
    set_gate(1'b1);
    do_tick(1); chk("R8 mode5 trig", 16'd2, 1'b0);
    do_tick(2); chk("R8 mode5 strobe", 16'd0, 1'b1);
    do_tick(1); chk("R9 wrap mode5", 16'hFFFF, 1'b0);
    set_gate(1'b0);
    set_gate(1'b1);
    do_tick(1); chk("R8 mode5 rearm", 16'd2, 1'b0);
  endtask

  task automatic t_zero;
    do_load(3'd2, 16'd0);
    do_tick(1); chk("R2 zero load", 16'd0, 1'b0);
    do_tick(1); chk("R2 zero is 65536", 16'hFFFF, 1'b0);
    do_load(3'd3, 16'd0);
    do_tick(1); chk("R2 square zero", 16'd0, 1'b1);
    do_tick(1); chk("R2 square step", 16'hFFFE, 1'b1);
  endtask

  task automatic t_midload;
    do_load(3'd2, 16'd9);
    do_tick(2); chk("R10 run", 16'd8, 1'b0);
    do_load(3'd2, 16'd4);
    repeat (3) @(negedge clk);
    chk("R10 load waits for tick", 16'd8, 1'b0);
    do_tick(1); chk("R10 new count", 16'd4, 1'b0);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode45();
    t_zero();
    t_midload();
    finished = 1;
    summary();
  end
endmodule